// File: doc/BRIEF.md
# Boot Enable Latch with Reset Lockout

This block sits on a host processor's bus. It keeps two downstream circuits switched off until the host has finished booting. The host then opts in by writing to one decoded address. Each enable bit is sticky: bus traffic never clears it. The outputs toward the downstream circuits are the complements of the enable bits, so a clear bit holds its circuit off. There is no free-running clock. State changes only on the trailing edge of the write strobe, on the board reset input and on a dedicated power-on input.

The board reset input is noisy. Only its first assertion after power-on is honoured. When that first pulse ends, an internal lockout flag is set and the reset input is gated off. Later spikes on it then leave the enables alone. Only the power-on input clears the lockout flag and re-arms the reset. The host can read the enable bits back at the same decoded address. The read path uses a split data bus, with a drive-enable flag in place of a tri-state pin. The block has no streaming data path, so every pin is a plain control or data pin.

Top module: `boot_enable_latch`

## Requirements
- R1: On the rising edge of `wr_n`, with `addr` equal to `EN_ADDR`, a 1 in `wr_data[0]` sets `enable[0]` and a 1 in `wr_data[1]` sets `enable[1]`.
- R2: Writing 0 to an enable bit leaves it unchanged. No bus read or write ever clears a set enable bit.
- R3: A write to any address other than `EN_ADDR` leaves both enable bits and the lockout state unchanged.
- R4: While `por_n` is low, both enable bits are 0 and the lockout is cleared. After `por_n` is released, the next board reset pulse clears the enables again.
- R5: While the lockout is clear, a low level on `ext_rst_n` forces both enable bits to 0 and holds them there for as long as it stays low.
- R6: Once the first `ext_rst_n` pulse after power-on has ended, any further low pulse on `ext_rst_n`, however short, leaves the enable bits unchanged.
- R7: While `rd_n` is low and `addr` equals `EN_ADDR`, `rd_drive` is 1 and `rd_data` equals the two enable bits in bits 1:0, with all higher bits 0.
- R8: When no read to `EN_ADDR` is in progress, `rd_drive` is 0 and `rd_data` is all zeros.
- R9: `hold_off[i]` is always the complement of `enable[i]`, so a downstream circuit stays disabled while its enable bit is clear.
- R10: A write whose trailing edge falls inside a board reset pulse is lost if that pulse is the first since power-on. If the lockout is already set, the write takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| por_n | input | 1 | Power-on clear, active low; clears enables and lockout |
| ext_rst_n | input | 1 | Noisy board reset, active low; honoured only until lockout |
| addr | input | ADDR_W | Host address bus |
| wr_n | input | 1 | Write strobe, active low; enables update on its rising edge |
| rd_n | input | 1 | Read strobe, active low |
| wr_data | input | DATA_W | Host write data |
| rd_data | output | DATA_W | Read-back data, zero when not driving |
| rd_drive | output | 1 | High while the block drives read data |
| enable | output | 2 | Sticky enable bits, active high |
| hold_off | output | 2 | Disable lines to the external circuits, complement of enable |

## Verification
Two functions can meet in the same instant: the trailing edge of a host write, and a board reset pulse. The bench opens a write strobe, pulls `ext_rst_n` low, releases the write while the reset is still low, and only then ends the reset pulse. It does this once while the reset is still armed, where the write must be lost, and once after lockout, where the write must land. The behavioural model applies the same rule at the same instant. Every clock, the bench compares the enables, the disable lines and the read port against that model.

// File: rtl/boot_enable_pkg.sv
`timescale 1ns/1ps
package boot_enable_pkg;
  localparam int unsigned NUM_EN = 2;
  typedef logic [NUM_EN-1:0] en_vec_t;
endpackage

// File: rtl/rst_lockout.sv
`timescale 1ns/1ps
// Records the end of the first board reset after power-on and masks the
// board reset from then on. Produces the combined clear for the enables.
module rst_lockout (
  input  logic por_n,
  input  logic ext_rst_n,
  output logic locked,
  output logic clr_n
);
  logic lock_q;

  always_ff @(posedge ext_rst_n or negedge por_n) begin
    if (!por_n) lock_q <= 1'b0;
    else        lock_q <= 1'b1;
  end

  assign locked = lock_q;
  assign clr_n  = por_n & (ext_rst_n | lock_q);
endmodule

// File: rtl/en_bank.sv
`timescale 1ns/1ps
// Sticky set-only enable bits, updated on the trailing write edge.
module en_bank
  import boot_enable_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] EN_ADDR = 16'h3F2C
) (
  input  logic              clr_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output en_vec_t           en
);
  logic hit;
  assign hit = (addr == EN_ADDR);

  for (genvar i = 0; i < NUM_EN; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge wr_n or negedge clr_n) begin
      if (!clr_n)                  bit_q <= 1'b0;
      else if (hit && wr_data[i])  bit_q <= 1'b1;
    end
    assign en[i] = bit_q;
  end
endmodule

// File: rtl/rd_port.sv
`timescale 1ns/1ps
// Read-back of the enable bits at the decoded address.
module rd_port
  import boot_enable_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] EN_ADDR = 16'h3F2C
) (
  input  logic              rd_n,
  input  logic [ADDR_W-1:0] addr,
  input  en_vec_t           en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_drive
);
  localparam int unsigned PAD_W = DATA_W - NUM_EN;

  always_comb begin
    rd_drive = !rd_n && (addr == EN_ADDR);
    rd_data  = '0;
    if (rd_drive) rd_data = {{PAD_W{1'b0}}, en};
  end
endmodule

// File: rtl/boot_enable_latch.sv
`timescale 1ns/1ps
module boot_enable_latch
  import boot_enable_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] EN_ADDR = 16'h3F2C
) (
  input  logic              por_n,
  input  logic              ext_rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_drive,
  output logic [1:0]        enable,
  output logic [1:0]        hold_off
);
  logic    locked;
  logic    clr_n;
  en_vec_t en;

  rst_lockout u_lock (
    .por_n     (por_n),
    .ext_rst_n (ext_rst_n),
    .locked    (locked),
    .clr_n     (clr_n)
  );

  en_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .EN_ADDR(EN_ADDR)) u_bank (
    .clr_n   (clr_n),
    .wr_n    (wr_n),
    .addr    (addr),
    .wr_data (wr_data),
    .en      (en)
  );

  rd_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .EN_ADDR(EN_ADDR)) u_rd (
    .rd_n     (rd_n),
    .addr     (addr),
    .en       (en),
    .rd_data  (rd_data),
    .rd_drive (rd_drive)
  );

  assign enable   = en;
  assign hold_off = ~en;
endmodule

// File: rtl/boot_enable_latch_chk.sv
`timescale 1ns/1ps
module boot_enable_latch_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] EN_ADDR = 16'h3F2C
) (
  input logic              por_n,
  input logic              wr_n,
  input logic              rd_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_drive,
  input logic [1:0]        enable,
  input logic              locked
);
  // High once a write edge has occurred since the last power-on,
  // so $past at a write edge stays within one power-on epoch.
  logic wr_seen;
  always_ff @(posedge wr_n or negedge por_n) begin
    if (!por_n) wr_seen <= 1'b0;
    else        wr_seen <= 1'b1;
  end

  // R1: after lockout, a decoded write's set bits appear by the next write edge
  assert_set_bits_R1: assert property (@(posedge wr_n) disable iff (!por_n)
    (wr_seen && $past(locked) && locked && $past(addr == EN_ADDR))
      |-> ((enable & $past(wr_data[1:0])) == $past(wr_data[1:0])));

  // R2 / R6: after lockout, enable bits only ever grow
  assert_sticky_R6: assert property (@(posedge wr_n) disable iff (!por_n)
    (wr_seen && $past(locked) && locked)
      |-> ((enable & $past(enable)) == $past(enable)));

  // R3: a write elsewhere changes nothing
  assert_other_addr_R3: assert property (@(posedge wr_n) disable iff (!por_n)
    (wr_seen && $past(locked) && locked && $past(addr != EN_ADDR))
      |-> (enable == $past(enable)));

  // R4: lockout only drops through power-on
  assert_lock_kept_R4: assert property (@(posedge wr_n) disable iff (!por_n)
    (wr_seen && $past(locked)) |-> locked);

  // R7: a read of the enable address returns the enable bits
  assert_rd_back_R7: assert property (@(posedge rd_n) disable iff (!por_n)
    (addr == EN_ADDR) |-> (rd_drive && rd_data == {{(DATA_W-2){1'b0}}, enable}));

  // R8: bus is quiet while a write completes
  assert_rd_quiet_R8: assert property (@(posedge wr_n) disable iff (!por_n)
    rd_n |-> (!rd_drive && rd_data == '0));
endmodule

bind boot_enable_latch boot_enable_latch_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EN_ADDR(EN_ADDR)
) u_chk (
  .por_n    (por_n),
  .wr_n     (wr_n),
  .rd_n     (rd_n),
  .addr     (addr),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .rd_drive (rd_drive),
  .enable   (enable),
  .locked   (locked)
);

// File: tb/boot_enable_latch_bench.sv
`timescale 1ns/1ps
module boot_enable_latch_bench;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] EA = 16'h3F2C;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              por_n = 1'b0;
  logic              ext_rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              wr_n = 1'b1;
  logic              rd_n = 1'b1;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic              rd_drive;
  logic [1:0]        enable;
  logic [1:0]        hold_off;

  boot_enable_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .EN_ADDR(EA)) u_boot_enable_latch (
    .por_n(por_n), .ext_rst_n(ext_rst_n), .addr(addr), .wr_n(wr_n), .rd_n(rd_n),
    .wr_data(wr_data), .rd_data(rd_data), .rd_drive(rd_drive),
    .enable(enable), .hold_off(hold_off)
  );

  // Behavioural reference
  int   tests = 0;
  int   fails = 0;
  bit   m_locked = 0;
  bit [1:0] m_en = 2'b00;
  string phase = "R4";
  bit   done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (por_n && !done) begin
      bit               exp_drv;
      logic [DATA_W-1:0] exp_rd;
      exp_drv = !rd_n && (addr == EA);
      exp_rd  = exp_drv ? {6'b0, m_en} : '0;
      chk(enable == m_en, phase, enable, m_en);
      chk(hold_off == ~m_en, "R9", hold_off, ~m_en);
      chk(rd_drive == exp_drv, exp_drv ? "R7" : "R8", rd_drive, exp_drv);
      chk(rd_data == exp_rd, exp_drv ? "R7" : "R8", rd_data, exp_rd);
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic power_on();
    por_n = 1'b0; m_en = 2'b00; m_locked = 0;
    tick(2);
    por_n = 1'b1;
    tick(1);
  endtask

  task automatic ext_pulse(input int len);
    ext_rst_n = 1'b0;
    if (!m_locked) m_en = 2'b00;
    tick(len);
    ext_rst_n = 1'b1; m_locked = 1;
    tick(1);
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    addr = a; wr_data = d; wr_n = 1'b0;
    tick(2);
    wr_n = 1'b1;
    if (a == EA && (m_locked || ext_rst_n)) m_en = m_en | d[1:0];
    tick(1);
  endtask

  // Write whose trailing edge falls inside a board reset pulse
  task automatic write_in_spike(input logic [DATA_W-1:0] d);
    addr = EA; wr_data = d; wr_n = 1'b0;
    tick(1);
    ext_rst_n = 1'b0;
    if (!m_locked) m_en = 2'b00;
    #0.5;
    wr_n = 1'b1;
    if (m_locked) m_en = m_en | d[1:0];
    #0.5;
    ext_rst_n = 1'b1; m_locked = 1;
    tick(1);
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, input string tag, input bit exp_drv);
    addr = a; rd_n = 1'b0;
    tick(1);
    #0.5;
    chk(rd_drive == exp_drv, tag, rd_drive, exp_drv);
    if (exp_drv) chk(rd_data == {6'b0, m_en}, tag, rd_data, {6'b0, m_en});
    tick(1);
    rd_n = 1'b1;
    tick(1);
  endtask

  initial begin
    #(200000 * 5);
    chk(0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tick(1);
    power_on();
    // R4: cleared after power-on
    chk(enable == 2'b00 && hold_off == 2'b11, "R4", enable, 0);
    // R5: write while the first board reset is held low is lost
    phase = "R5";
    bus_write(EA, 8'h03);
    chk(enable == 2'b00, "R5", enable, 0);
    ext_rst_n = 1'b1; m_locked = 1; tick(1);
    // R1
    phase = "R1";
    bus_write(EA, 8'h01);
    chk(enable == 2'b01, "R1", enable, 1);
    // R3
    phase = "R3";
    bus_write(EA ^ 16'h0001, 8'h03);
    chk(enable == 2'b01, "R3", enable, 1);
    bus_write(16'h0000, 8'hFF);
    chk(enable == 2'b01, "R3", enable, 1);
    // R2
    phase = "R2";
    bus_write(EA, 8'h00);
    chk(enable == 2'b01, "R2", enable, 1);
    bus_write(EA, 8'hFC);
    chk(enable == 2'b01, "R2", enable, 1);
    bus_read(EA, "R7", 1'b1);
    chk(enable == 2'b01, "R2", enable, 1);
    phase = "R1";
    bus_write(EA, 8'h02);
    chk(enable == 2'b11, "R1", enable, 3);
    chk(hold_off == 2'b00, "R9", hold_off, 0);
    // R7 / R8
    bus_read(EA, "R7", 1'b1);
    bus_read(EA ^ 16'h8000, "R8", 1'b0);
    // R6: spikes after lockout
    phase = "R6";
    ext_pulse(1);
    chk(enable == 2'b11, "R6", enable, 3);
    ext_pulse(5);
    chk(enable == 2'b11, "R6", enable, 3);
    // R4: power-on re-arms
    phase = "R4";
    power_on();
    chk(enable == 2'b00, "R4", enable, 0);
    bus_write(EA, 8'h02);
    chk(enable == 2'b10, "R4", enable, 2);
    ext_pulse(3);
    chk(enable == 2'b00, "R4", enable, 0);
    // R10 armed: write in first spike lost
    phase = "R10";
    power_on();
    write_in_spike(8'h01);
    chk(enable == 2'b00, "R10", enable, 0);
    // R10 locked: write in spike lands
    write_in_spike(8'h02);
    chk(enable == 2'b10, "R10", enable, 2);
    ext_pulse(2);
    chk(enable == 2'b10, "R6", enable, 2);
    bus_read(EA, "R7", 1'b1);
    tick(2);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule